// File: doc/BRIEF.md
# Global Overflow Status Register Bank

This block gathers the overflow indications of a performance-monitoring unit into one 64-bit read-only status word. Each source raises its own one-cycle set pulse: up to eight general-purpose counters, three fixed-function counters, an uncore overflow, a sample-buffer overflow and a configuration-changed event. A flag stays set until software clears it.

Software clears flags through a companion 64-bit control register. Its bit layout matches the status word. A single write can clear any mix of general, fixed and special flags at once. The control register is write-only in effect and always reads back as zero. The parameter `GP_IMPL` gives the number of implemented general counters. The flags for general counters 4 to 7 exist only when all eight counters are implemented.

Top module: `gov_status_bank`

## Requirements
- R1: With `rst` held high on a clock edge, `status` reads all zeros after that edge.
- R2: A pulse on `gp_set[i]` sets `status[i]` for general counter i (bit 0 is counter 0, up to bit 7 for counter 7). The bit is visible one clock later and stays set with no further pulse.
- R3: A pulse on `fix_set[k]` sets `status[32+k]` one clock later, for fixed counters k = 0, 1, 2.
- R4: `uncore_set`, `sbuf_set` and `cond_set` set `status[61]`, `status[62]` and `status[63]` one clock later.
- R5: Status bits 8 to 31 and 35 to 60 always read as zero.
- R6: A control write (`ctl_wr_en` high) with a 1 in bit j clears `status[j]` one clock later. A 0 in bit j leaves that flag unchanged.
- R7: One control write clears every flag whose control bit is 1, across general, fixed and special positions, in the same cycle.
- R8: When a set pulse and a control-write clear target the same bit in the same cycle, the bit is set afterwards.
- R9: `ctl_rd_data` reads zero at all times, including after writes.
- R10: When `GP_IMPL` is not 8, `status[7:4]` reads zero even while `gp_set[7:4]` pulse. Lower counters up to min(`GP_IMPL`,4) still work.
- R11: While `ctl_wr_en` is low, `ctl_wr_data` has no effect and no set flag drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gp_set | input | 8 | Overflow set pulses, general counters 0..7 |
| fix_set | input | 3 | Overflow set pulses, fixed counters 0..2 |
| uncore_set | input | 1 | Uncore overflow set pulse |
| sbuf_set | input | 1 | Sample-buffer overflow set pulse |
| cond_set | input | 1 | Configuration-changed set pulse |
| ctl_wr_en | input | 1 | Write strobe for the clear control register |
| ctl_wr_data | input | 64 | Clear mask, same layout as `status` |
| status | output | 64 | Registered overflow status word |
| ctl_rd_data | output | 64 | Control register read value, always zero |

## Verification
Every flag is a register that drives `status` directly. A wrong flag state therefore shows at the port on the very next clock edge, either as a set bit that should be clear or a clear bit that should be set. A lost clear keeps its bit high after the write cycle. A wrong set/clear priority shows as a dropped bit in the cycle after the collision. A mis-wired position or presence mask puts a one in a reserved field, or in bits 7:4 of the four-counter instance, as soon as any source pulses.

// File: rtl/gov_pkg.sv
package gov_pkg;
  localparam int STAT_W   = 64;
  localparam int GP_MAX   = 8;
  localparam int GP_LOW   = 4;
  localparam int FIX_N    = 3;
  localparam int FIX_LSB  = 32;
  localparam int UNC_BIT  = 61;
  localparam int SBUF_BIT = 62;
  localparam int COND_BIT = 63;

  // Positions that hold a real flag for a given general-counter count
  function automatic logic [STAT_W-1:0] live_mask(input int gp_impl);
    logic [STAT_W-1:0] m;
    int gp_live;
    if (gp_impl >= GP_MAX)     gp_live = GP_MAX;
    else if (gp_impl > GP_LOW) gp_live = GP_LOW;
    else                       gp_live = gp_impl;
    m = '0;
    for (int i = 0; i < GP_MAX; i++)
      if (i < gp_live) m[i] = 1'b1;
    for (int k = 0; k < FIX_N; k++)
      m[FIX_LSB + k] = 1'b1;
    m[UNC_BIT]  = 1'b1;
    m[SBUF_BIT] = 1'b1;
    m[COND_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gov_set_gather.sv
module gov_set_gather
  import gov_pkg::*;
#(
  parameter int GP_IMPL = 8
) (
  input  logic [GP_MAX-1:0] gp_set,
  input  logic [FIX_N-1:0]  fix_set,
  input  logic              uncore_set,
  input  logic              sbuf_set,
  input  logic              cond_set,
  output logic [STAT_W-1:0] set_vec
);
  localparam logic [STAT_W-1:0] MASK = live_mask(GP_IMPL);

  logic [STAT_W-1:0] raw;

  always_comb begin
    raw = '0;
    raw[GP_MAX-1:0]         = gp_set;
    raw[FIX_LSB +: FIX_N]   = fix_set;
    raw[UNC_BIT]            = uncore_set;
    raw[SBUF_BIT]           = sbuf_set;
    raw[COND_BIT]           = cond_set;
    set_vec = raw & MASK;
  end
endmodule

// File: rtl/gov_clear_decode.sv
module gov_clear_decode
  import gov_pkg::*;
#(
  parameter int GP_IMPL = 8
) (
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] clr_vec
);
  localparam logic [STAT_W-1:0] MASK = live_mask(GP_IMPL);

  always_comb begin
    if (wr_en) clr_vec = wr_data & MASK;
    else       clr_vec = '0;
  end
endmodule

// File: rtl/gov_flag_cell.sv
module gov_flag_cell #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  generate
    if (PRESENT) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;   // set has priority over clear
        else if (clr) q <= 1'b0;
      end
    end else begin : g_tie
      logic unused_in;
      assign unused_in = &{1'b0, clk, rst, set, clr};
      assign q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gov_status_bank.sv
module gov_status_bank
  import gov_pkg::*;
#(
  parameter int GP_IMPL = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GP_MAX-1:0] gp_set,
  input  logic [FIX_N-1:0]  fix_set,
  input  logic              uncore_set,
  input  logic              sbuf_set,
  input  logic              cond_set,
  input  logic              ctl_wr_en,
  input  logic [STAT_W-1:0] ctl_wr_data,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] ctl_rd_data
);
  localparam logic [STAT_W-1:0] MASK = live_mask(GP_IMPL);

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] flags;

  gov_set_gather #(.GP_IMPL(GP_IMPL)) u_gather (
    .gp_set     (gp_set),
    .fix_set    (fix_set),
    .uncore_set (uncore_set),
    .sbuf_set   (sbuf_set),
    .cond_set   (cond_set),
    .set_vec    (set_vec)
  );

  gov_clear_decode #(.GP_IMPL(GP_IMPL)) u_clear (
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .clr_vec (clr_vec)
  );

  generate
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      gov_flag_cell #(.PRESENT(MASK[b])) u_cell (
        .clk (clk),
        .rst (rst),
        .set (set_vec[b]),
        .clr (clr_vec[b]),
        .q   (flags[b])
      );
    end
  endgenerate

  assign status      = flags;
  assign ctl_rd_data = '0;
endmodule

// File: rtl/gov_status_bank_chk.sv
module gov_status_bank_chk
  import gov_pkg::*;
#(
  parameter int GP_IMPL = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [GP_MAX-1:0] gp_set,
  input logic [FIX_N-1:0]  fix_set,
  input logic              uncore_set,
  input logic              sbuf_set,
  input logic              cond_set,
  input logic              ctl_wr_en,
  input logic [STAT_W-1:0] ctl_wr_data,
  input logic [STAT_W-1:0] status
);
  localparam logic [STAT_W-1:0] MASK = live_mask(GP_IMPL);

  assert_gp0_set_R2: assert property (@(posedge clk) disable iff (rst)
    gp_set[0] |=> status[0]);

  assert_fix0_set_R3: assert property (@(posedge clk) disable iff (rst)
    fix_set[0] |=> status[FIX_LSB]);

  assert_special_set_R4: assert property (@(posedge clk) disable iff (rst)
    (uncore_set && sbuf_set && cond_set) |=> (status[UNC_BIT] && status[SBUF_BIT] && status[COND_BIT]));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (status & ~MASK) == '0);

  assert_fix0_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data[FIX_LSB] && !fix_set[0]) |=> !status[FIX_LSB]);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (gp_set[1] && ctl_wr_en && ctl_wr_data[1]) |=> status[1]);

  assert_upper_absent_R10: assert property (@(posedge clk) disable iff (rst)
    (GP_IMPL != GP_MAX) |-> (status[7:4] == 4'b0000));

  assert_no_drop_R11: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr_en |=> ((status & $past(status)) == $past(status)));
endmodule

bind gov_status_bank gov_status_bank_chk #(.GP_IMPL(GP_IMPL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .gp_set      (gp_set),
  .fix_set     (fix_set),
  .uncore_set  (uncore_set),
  .sbuf_set    (sbuf_set),
  .cond_set    (cond_set),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_wr_data (ctl_wr_data),
  .status      (status)
);

// File: tb/test_gov_status_bank.sv
module test_gov_status_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  gp_set = '0;
  logic [2:0]  fix_set = '0;
  logic        uncore_set = 1'b0;
  logic        sbuf_set = 1'b0;
  logic        cond_set = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [63:0] ctl_wr_data = '0;
  logic [63:0] status, status4;
  logic [63:0] ctl_rd, ctl_rd4;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reserved positions: bits 8..31 and 35..60
  localparam logic [63:0] RESV = 64'h1FFF_FFF8_FFFF_FF00;

  always #(CLK_PERIOD/2) clk = ~clk;

  gov_status_bank #(.GP_IMPL(8)) i_gov_status_bank (
    .clk(clk), .rst(rst), .gp_set(gp_set), .fix_set(fix_set),
    .uncore_set(uncore_set), .sbuf_set(sbuf_set), .cond_set(cond_set),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .status(status), .ctl_rd_data(ctl_rd));

  gov_status_bank #(.GP_IMPL(4)) i_gov_status_bank_g4 (
    .clk(clk), .rst(rst), .gp_set(gp_set), .fix_set(fix_set),
    .uncore_set(uncore_set), .sbuf_set(sbuf_set), .cond_set(cond_set),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .status(status4), .ctl_rd_data(ctl_rd4));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, return at the next falling edge
  task automatic step(input logic [7:0] g, input logic [2:0] f, input logic u,
                      input logic s, input logic c, input logic we, input logic [63:0] d);
    @(negedge clk);
    gp_set = g; fix_set = f; uncore_set = u; sbuf_set = s; cond_set = c;
    ctl_wr_en = we; ctl_wr_data = d;
    @(negedge clk);
    gp_set = '0; fix_set = '0; uncore_set = 1'b0; sbuf_set = 1'b0; cond_set = 1'b0;
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
  endtask

  task automatic t_reset;
    step(8'hFF, 3'b111, 1, 1, 1, 0, '0);
    rst = 1'b1;
    step('0, '0, 0, 0, 0, 0, '0);
    rst = 1'b0;
    check("R1 status after reset", status, 64'h0);
    check("R1 status4 after reset", status4, 64'h0);
    check("R9 ctl read after reset", ctl_rd, 64'h0);
  endtask

  task automatic t_gp;
    step(8'hA5, '0, 0, 0, 0, 0, '0);
    check("R2 general bits", status, 64'h0000_0000_0000_00A5);
    step('0, '0, 0, 0, 0, 0, '0);
    check("R2 general bits sticky", status, 64'h0000_0000_0000_00A5);
    check("R10 four-counter instance", status4, 64'h0000_0000_0000_0005);
  endtask

  task automatic t_fixed;
    step('0, 3'b101, 0, 0, 0, 0, '0);
    check("R3 fixed 0 and 2", status, 64'h0000_0005_0000_00A5);
    step('0, 3'b010, 0, 0, 0, 0, '0);
    check("R3 fixed 1", status, 64'h0000_0007_0000_00A5);
  endtask

  task automatic t_special;
    step('0, '0, 1, 0, 0, 0, '0);
    check("R4 uncore bit 61", status, 64'h2000_0007_0000_00A5);
    step('0, '0, 0, 1, 0, 0, '0);
    check("R4 buffer bit 62", status, 64'h6000_0007_0000_00A5);
    step('0, '0, 0, 0, 1, 0, '0);
    check("R4 cond bit 63", status, 64'hE000_0007_0000_00A5);
  endtask

  task automatic t_reserved;
    step(8'hFF, 3'b111, 1, 1, 1, 0, '0);
    check("R5 reserved zero", status & RESV, 64'h0);
    check("R5 full image", status, 64'hE000_0007_0000_00FF);
    check("R10 upper general absent", status4[7:4], 64'h0);
    check("R5 reserved zero g4", status4 & RESV, 64'h0);
  endtask

  task automatic t_no_wren;
    step('0, '0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R11 data ignored without strobe", status, 64'hE000_0007_0000_00FF);
  endtask

  task automatic t_clear_single;
    step('0, '0, 0, 0, 0, 1, 64'h0000_0000_0000_0001);
    check("R6 clear bit 0 only", status, 64'hE000_0007_0000_00FE);
    step('0, '0, 0, 0, 0, 1, 64'h0);
    check("R6 zero write no change", status, 64'hE000_0007_0000_00FE);
    check("R9 ctl read after write", ctl_rd, 64'h0);
  endtask

  task automatic t_clear_multi;
    step('0, '0, 0, 0, 0, 1, 64'h4000_0002_0000_0030);
    check("R7 mixed clear", status, 64'hA000_0005_0000_00CE);
    step('0, '0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 clear all", status, 64'h0);
    check("R7 clear all g4", status4, 64'h0);
  endtask

  task automatic t_set_wins;
    step(8'h08, 3'b001, 0, 0, 0, 1, 64'h0000_0001_0000_0008);
    check("R8 set beats clear", status, 64'h0000_0001_0000_0008);
    step('0, '0, 0, 0, 0, 1, 64'h0000_0001_0000_0008);
    check("R6 later clear works", status, 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_gp();
    t_fixed();
    t_special();
    t_reserved();
    t_no_wren();
    t_clear_single();
    t_clear_multi();
    t_set_wins();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule